// File: doc/BRIEF.md
# Memory-Card Slot Status Register Block

This block sits on a word-indexed register bus and tells software what a memory-card slot is doing. Two slot signals enter from pads: a write-protect level and a card-present level. Both pass through a two-flop synchroniser. The synchronised write-protect level is reported live. The card-present level sets a sticky insertion flag. That flag stays set until software clears it, and it drives a single level interrupt toward the system interrupt controller.

Three more word indices return constants: an identification word, a word that reads as zero, and a decode-configuration word. Software may write those indices and the writes change nothing. Reads are combinational from the index and the current state, so read data is valid in the same cycle as the index. Writes take effect at the rising clock edge. Reset is asynchronous and active low, and it clears all state.

Top module: `slot_status_regs`

## Requirements
- R1: Index 0 reads 0x41034003, index 1 reads 0x00000000 and index 3 reads 0x00000011.
- R2: Every index above 3 reads 0x00000000.
- R3: Index 2 bit 0 shows the write-protect input as it was two rising edges earlier, through the synchroniser. All bits of index 2 other than 0 and 3 read zero.
- R4: Index 2 bit 3 is the insertion flag. The flag sets at the third rising edge after the card input goes high, and it stays set after the input falls.
- R5: A write to index 2 whose bit 3 is one clears the flag at that edge. A write to index 2 whose bit 3 is zero leaves the flag alone, and no write changes bit 0.
- R6: When the synchronised card input is high at the edge of a clearing write, the flag stays set.
- R7: The interrupt output is high exactly when the insertion flag is set.
- R8: Writes to indices 1, 3 and any other index except 2 have no effect on any read value or on the interrupt.
- R9: While reset is low, index 2 reads zero and the interrupt is low, whatever the slot inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_in | input | 1 | Write-protect level from the slot, asynchronous |
| card_in | input | 1 | Card-present level from the slot, asynchronous |
| reg_idx | input | IDX_W | Word index of the register access |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for reg_idx, combinational |
| card_irq | output | 1 | Card-insertion interrupt, level |

## Verification
The bench aims at the collision between a clearing write and a card input that is still high. A design in which clear has priority would drop the flag and lose an insertion. It also pulses the card input for a single cycle and then drops it. A design that passes the level through would let the flag and the interrupt fall on their own. Writes whose bit 3 is zero, and writes with random data to the constant and undefined indices, catch decoders that compare too few index bits, that clear without looking at the data bit, or that let a write disturb the write-protect bit. Reset is held with both slot inputs high, and the release timing is counted to the edge, so a missing or extra synchroniser stage shows up as a one-cycle shift.

// File: rtl/slot_status_pkg.sv
package slot_status_pkg;
   // Word indices; the status index and its bit positions are decoded by software
   localparam int unsigned IDX_IDENT  = 0;
   localparam int unsigned IDX_ZERO   = 1;
   localparam int unsigned IDX_STATUS = 2;
   localparam int unsigned IDX_DECODE = 3;

   localparam logic [31:0] IDENT_WORD_DEF  = 32'h4103_4003;
   localparam logic [31:0] DECODE_WORD_DEF = 32'h0000_0011;

   // Positions inside the synchronised input vector
   localparam int unsigned SYN_WP   = 0;
   localparam int unsigned SYN_CARD = 1;
   localparam int unsigned SYN_W    = 2;
endpackage

// File: rtl/slot_sync.sv
module slot_sync #(
   parameter int unsigned W      = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] d_sync
);
   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("slot_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("slot_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign d_sync = chain_q[LAST];
endmodule

// File: rtl/slot_sticky.sv
module slot_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   // Set has priority so an insertion seen in the clearing cycle is kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_q <= 1'b0;
      else if (set_i) flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
   assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
   assert_flag_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/slot_bus_dec.sv
module slot_bus_dec
   import slot_status_pkg::*;
#(
   parameter int unsigned     DATA_W      = 32,
   parameter int unsigned     IDX_W       = 4,
   parameter int unsigned     WP_BIT      = 0,
   parameter int unsigned     CARD_BIT    = 3,
   parameter logic [DATA_W-1:0] IDENT_WORD  = DATA_W'(IDENT_WORD_DEF),
   parameter logic [DATA_W-1:0] DECODE_WORD = DATA_W'(DECODE_WORD_DEF)
) (
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wp_live,
   input  logic              card_flag,
   output logic              clr_req,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [IDX_W-1:0] I_IDENT  = IDX_W'(IDX_IDENT);
   localparam logic [IDX_W-1:0] I_ZERO   = IDX_W'(IDX_ZERO);
   localparam logic [IDX_W-1:0] I_STATUS = IDX_W'(IDX_STATUS);
   localparam logic [IDX_W-1:0] I_DECODE = IDX_W'(IDX_DECODE);

   logic hit_status;
   assign hit_status = (reg_idx == I_STATUS);

   // Only the card bit of a status write matters; all other data is dropped
   assign clr_req = wr_en && hit_status && wr_data[CARD_BIT];

   logic unused_wdata;
   assign unused_wdata = ^wr_data;

   always_comb begin
      rd_data = '0;
      if (reg_idx == I_IDENT) begin
         rd_data = IDENT_WORD;
      end else if (reg_idx == I_ZERO) begin
         rd_data = '0;
      end else if (hit_status) begin
         rd_data[WP_BIT]   = wp_live;
         rd_data[CARD_BIT] = card_flag;
      end else if (reg_idx == I_DECODE) begin
         rd_data = DECODE_WORD;
      end
   end
endmodule

// File: rtl/slot_status_regs.sv
module slot_status_regs
   import slot_status_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned IDX_W       = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned WP_BIT      = 0,
   parameter int unsigned CARD_BIT    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_in,
   input  logic              card_in,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              card_irq
);
   localparam logic [IDX_W-1:0] I_STATUS = IDX_W'(IDX_STATUS);
   localparam logic [IDX_W-1:0] I_LAST   = IDX_W'(IDX_DECODE);

   generate
      if (DATA_W < 32) begin : g_bad_data_w
         $error("slot_status_regs: DATA_W must hold the 32-bit constants");
      end
      if (IDX_W < 2) begin : g_bad_idx_w
         $error("slot_status_regs: IDX_W must address four words");
      end
      if (WP_BIT == CARD_BIT || WP_BIT >= DATA_W || CARD_BIT >= DATA_W) begin : g_bad_bits
         $error("slot_status_regs: status bit positions invalid");
      end
   endgenerate

   logic [SYN_W-1:0] raw_in;
   logic [SYN_W-1:0] syn_in;
   logic             flag;
   logic             clr_req;

   assign raw_in[SYN_WP]   = wp_in;
   assign raw_in[SYN_CARD] = card_in;

   slot_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (raw_in),
      .d_sync  (syn_in)
   );

   slot_sticky u_sticky (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (syn_in[SYN_CARD]),
      .clr_i  (clr_req),
      .flag_o (flag)
   );

   slot_bus_dec #(
      .DATA_W   (DATA_W),
      .IDX_W    (IDX_W),
      .WP_BIT   (WP_BIT),
      .CARD_BIT (CARD_BIT)
   ) u_dec (
      .reg_idx   (reg_idx),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .wp_live   (syn_in[SYN_WP]),
      .card_flag (flag),
      .clr_req   (clr_req),
      .rd_data   (rd_data)
   );

   assign card_irq = flag;

   assert_irq_matches_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_idx == I_STATUS) |-> (rd_data[CARD_BIT] == card_irq));
   assert_wp_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_idx == I_STATUS) |-> (rd_data[WP_BIT] == syn_in[SYN_WP]));
   assert_undef_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_idx > I_LAST) |-> (rd_data == '0));
   assert_other_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && reg_idx != I_STATUS && !syn_in[SYN_CARD]) |=> $stable(card_irq));
   assert_rise_needs_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !syn_in[SYN_CARD] |=> !$rose(card_irq));
endmodule

// File: tb/sim_slot_status_regs.sv
`timescale 1ns/1ps
module sim_slot_status_regs;
   localparam int DATA_W = 32;
   localparam int IDX_W  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wp_in = 1'b1;
   logic              card_in = 1'b1;
   logic [IDX_W-1:0]  reg_idx = 4'd2;
   logic              wr_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [DATA_W-1:0] rd_data;
   logic              card_irq;

   int checks = 0;
   int failures = 0;
   string bit3_tag = "R9";
   string const_tag = "R1";
   string irq_tag = "R9";
   bit done = 0;

   always #10 clk = ~clk;

   slot_status_regs u0 (
      .clk(clk), .rst_n(rst_n), .wp_in(wp_in), .card_in(card_in),
      .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .card_irq(card_irq)
   );

   // Reference model built from the requirements
   logic m_wp1, m_wp2, m_cd1, m_cd2, m_flag;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_wp1 <= 0; m_wp2 <= 0; m_cd1 <= 0; m_cd2 <= 0; m_flag <= 0;
      end else begin
         m_wp1 <= wp_in;   m_wp2 <= m_wp1;
         m_cd1 <= card_in; m_cd2 <= m_cd1;
         if (m_cd2) m_flag <= 1'b1;
         else if (wr_en && reg_idx == 4'd2 && wr_data[3]) m_flag <= 1'b0;
      end
   end

   function automatic logic [31:0] exp_rd(input logic [3:0] idx);
      case (idx)
         4'd0: return 32'h4103_4003;
         4'd3: return 32'h0000_0011;
         4'd2: return {28'd0, m_flag, 2'b00, m_wp2};
         default: return 32'd0;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s idx=%0d actual=%08h expected=%08h t=%0t", tag, reg_idx, act, exp, $time);
      end
   endtask

   task automatic check_now();
      logic [31:0] e;
      e = exp_rd(reg_idx);
      if (reg_idx == 4'd2) begin
         chk("R3", {31'd0, rd_data[0]}, {31'd0, e[0]});
         chk(bit3_tag, {31'd0, rd_data[3]}, {31'd0, e[3]});
         chk("R3", rd_data & 32'hFFFF_FFF6, 32'd0);
      end else if (reg_idx > 4'd3) begin
         chk("R2", rd_data, e);
      end else begin
         chk(const_tag, rd_data, e);
      end
      chk(irq_tag, {31'd0, card_irq}, {31'd0, m_flag});
   endtask

   task automatic step();
      @(negedge clk);
      check_now();
   endtask

   task automatic wr(input logic [3:0] idx, input logic [31:0] d);
      reg_idx = idx; wr_en = 1'b1; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      // R9: reset held with both inputs high
      repeat (3) step();
      rst_n = 1'b1;
      bit3_tag = "R4"; irq_tag = "R7";
      card_in = 1'b0; wp_in = 1'b0;
      repeat (4) step();

      // R4: single-cycle card pulse, flag must stay after the input falls
      card_in = 1'b1; step();
      card_in = 1'b0;
      repeat (6) step();

      // R3: write-protect level follows with two-edge delay
      wp_in = 1'b1; repeat (3) step();
      wp_in = 1'b0; repeat (3) step();
      wp_in = 1'b1; step();

      // R5: write with bit 3 clear keeps the flag, bit 3 set clears it
      bit3_tag = "R5";
      wr(4'd2, 32'hFFFF_FFF7); step();
      wr(4'd2, 32'h0000_0008); repeat (2) step();

      // R6: clearing writes while the card input stays high
      bit3_tag = "R6";
      card_in = 1'b1; repeat (3) step();
      repeat (4) wr(4'd2, 32'hFFFF_FFFF);
      card_in = 1'b0;
      repeat (2) step();
      repeat (2) wr(4'd2, 32'h0000_0008);
      step();

      // R8: writes elsewhere change nothing; flag set first
      bit3_tag = "R8"; const_tag = "R8";
      card_in = 1'b1; repeat (3) step(); card_in = 1'b0; repeat (3) step();
      wr(4'd1, 32'hFFFF_FFFF);
      wr(4'd3, 32'hFFFF_FFFF);
      wr(4'd0, 32'h0000_0008);
      wr(4'd6, 32'h0000_0008);
      wr(4'd10, 32'hFFFF_FFFF);
      for (int i = 0; i < 16; i++) begin
         reg_idx = 4'(i); step();
      end

      // Random mix
      bit3_tag = "R4 R5"; const_tag = "R1";
      for (int n = 0; n < 4000; n++) begin
         card_in = ($urandom_range(0, 15) == 0);
         if ($urandom_range(0, 7) == 0) wp_in = ~wp_in;
         reg_idx = ($urandom_range(0, 1) == 0) ? 4'd2 : 4'($urandom_range(0, 15));
         wr_en = ($urandom_range(0, 3) == 0);
         wr_data = $urandom();
         step();
      end
      wr_en = 1'b0;
      step();

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule